// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a countdown watchdog that sits behind a small 32-bit register port. Software programs a 16-bit timeout and picks a tick resolution on a side input. It then sets the run bit together with the kick bit to start the countdown, and must keep kicking before the count runs out. If the count reaches zero, the block issues a single-cycle request to the system controller. That request asks either for a reboot or for a shutdown, depending on a control bit. The block also sets a sticky expiry flag, which software clears by writing one to it.

A block-enable input gates everything. While it is low, the registers neither decode reads nor accept writes, and the countdown and its prescaler hold still. The prescaler turns the reference clock into ticks of 32 µs, 10 ms, 100 ms or 1 s. The reference frequency is a parameter, and the tick lengths are derived from it.

Top module: `wdog_periph`

## Requirements
- R1: After reset the control register reads 0x00000000, the count register reads 0x00000000, and both request outputs are low.
- R2: While `blk_en` is low, reads return zero, writes to any register have no effect, and the count and prescaler hold their values.
- R3: A write to offset 0x04 stores bits 15:0 as the timeout, and a written value of 0 is stored as 1. A read of offset 0x04 returns the remaining count in bits 15:0 and zero in bits 31:16.
- R4: Control register at offset 0x00: bit0 run, bit1 expired flag, bit2 action (0 reboot, 1 shutdown), bit3 expiry block, bits 6:4 reserved, bit7 kick. Bits 0, 2 and 3 read back as written, bit1 reads the expired flag, and bits 31:4 always read 0.
- R5: A control write with bit7=1 and bit0=1 reloads the count from the stored timeout and restarts the prescaler. A kick written with bit0=0 leaves the count unchanged.
- R6: While running, the count drops by exactly one every D clock cycles. D = max(1, floor(CLK_HZ·P)), where `res_sel` picks P: 0 gives 32 µs, 1 gives 10 ms, 2 gives 100 ms and 3 gives 1 s.
- R7: Clearing bit0 freezes both the count and the prescaler phase. Setting bit0 again without a kick resumes from the frozen phase.
- R8: When the count steps from 1 to 0, exactly one of `reboot_req` (action 0) or `shutdown_req` (action 1) is high for exactly one cycle. It rises at the same clock edge on which the count becomes 0, and the count then stays at 0.
- R9: Expiry sets the expired flag. The flag stays set through the request and through control writes with bit1=0, and a control write with bit1=1 clears it.
- R10: With bit3 set, the count still reaches 0, but neither request is raised and the expired flag is not set.
- R11: An access to any offset other than 0x00 and 0x04 reads zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_en | input | 1 | Block enable; gates decoding and counting |
| res_sel | input | 2 | Tick resolution select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational, zero when not reading |
| reboot_req | output | 1 | One-cycle reboot request on expiry |
| shutdown_req | output | 1 | One-cycle shutdown request on expiry |

## Verification
The hardest states to reach from the ports are an expiry at the coarse resolutions and the prescaler phase surviving a freeze. At 100 ms or 1 s per tick, an expiry takes millions of cycles at a realistic clock. The bench therefore builds the block with a low reference frequency, so a full tick costs 10,000 or 100,000 cycles, and samples on the exact cycle of each step. Phase retention is reached by stopping the counter two cycles into a three-cycle tick. The bench then resumes without a kick and expects the next decrement after one cycle rather than three.

// File: rtl/wdog_pkg.sv
// Shared constants and helpers for the watchdog peripheral.
// Assumes a byte-addressed register port with word-aligned registers.
package wdog_pkg;

    localparam int unsigned REG_CTRL  = 0;
    localparam int unsigned REG_COUNT = 4;

    localparam int CB_RUN     = 0;
    localparam int CB_FIRED   = 1;
    localparam int CB_ACTION  = 2;
    localparam int CB_DISABLE = 3;
    localparam int CB_KICK    = 7;

    // Reference cycles per tick for a resolution code, never below one.
    function automatic longint unsigned tick_cycles(input longint unsigned hz,
                                                    input int unsigned sel);
        longint unsigned us;
        longint unsigned c;
        case (sel)
            0:       us = 64'd32;
            1:       us = 64'd10000;
            2:       us = 64'd100000;
            default: us = 64'd1000000;
        endcase
        c = (hz * us) / 64'd1000000;
        if (c == 64'd0) c = 64'd1;
        return c;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
// Tick generator: divides the reference clock into one of four tick periods.
// Assumes res_sel is quasi-static; a change mid-period ends the period early
// at the latest, never late. Restart clears the phase.
module wdog_prescale
    import wdog_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       restart,
    input  logic [1:0] res_sel,
    output logic       tick
);
    localparam longint unsigned MAX_DIV = tick_cycles(CLK_HZ, 3);
    localparam int PW = $clog2(MAX_DIV + 64'd1);

    logic [PW-1:0] lim [4];
    logic [PW-1:0] pre_q;
    logic [PW-1:0] sel_lim;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        localparam longint unsigned DIV_G = tick_cycles(CLK_HZ, g);
        assign lim[g] = PW'(DIV_G - 64'd1);
    end

    assign sel_lim = lim[res_sel];
    assign tick    = run_en && (pre_q >= sel_lim);

    // Phase counter: restarts on reload, advances only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
        end else if (run_en) begin
            pre_q <= tick ? '0 : pre_q + PW'(1);
        end
    end

endmodule

// File: rtl/wdog_count.sv
// Countdown core: reload, decrement per tick, expiry detection, sticky
// expired flag and one-cycle action requests.
// Assumes reload has priority over a tick in the same cycle.
module wdog_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             block_exp,
    input  logic             act_sd,
    input  logic             fired_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fired_q,
    output logic             reboot_req,
    output logic             shutdown_req
);
    logic step;
    logic fire;

    assign step = active && tick && (cnt_q != '0);
    assign fire = step && (cnt_q == CNT_W'(1)) && !block_exp;

    // Remaining count: load on kick, step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= reload_val;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Expired flag: set by expiry, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
        end else if (fire) begin
            fired_q <= 1'b1;
        end else if (fired_clr) begin
            fired_q <= 1'b0;
        end
    end

    // Action requests: one cycle, routed by the action bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reboot_req   <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reboot_req   <= fire && !act_sd;
            shutdown_req <= fire && act_sd;
        end
    end

endmodule

// File: rtl/wdog_regs.sv
// Register decode: control and timeout storage, kick and clear strobes,
// combinational read mux. Assumes single-cycle write strobes.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              fired_q,
    output logic              run_q,
    output logic              act_q,
    output logic              dis_q,
    output logic [CNT_W-1:0]  tmo_q,
    output logic              reload,
    output logic              fired_clr,
    output logic [DATA_W-1:0] rdata
);
    logic hit_ctrl;
    logic hit_cnt;
    logic wr_ctrl;
    logic wr_cnt;
    logic unused_wdata;

    assign hit_ctrl  = (addr == ADDR_W'(REG_CTRL));
    assign hit_cnt   = (addr == ADDR_W'(REG_COUNT));
    assign wr_ctrl   = blk_en && wr_en && hit_ctrl;
    assign wr_cnt    = blk_en && wr_en && hit_cnt;
    assign reload    = wr_ctrl && wdata[CB_KICK] && wdata[CB_RUN];
    assign fired_clr = wr_ctrl && wdata[CB_FIRED];

    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

    // Control bits: run, action and expiry block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            act_q <= 1'b0;
            dis_q <= 1'b0;
        end else if (wr_ctrl) begin
            run_q <= wdata[CB_RUN];
            act_q <= wdata[CB_ACTION];
            dis_q <= wdata[CB_DISABLE];
        end
    end

    // Stored timeout, with zero promoted to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= '1;
        end else if (wr_cnt) begin
            tmo_q <= (wdata[CNT_W-1:0] == '0) ? CNT_W'(1) : wdata[CNT_W-1:0];
        end
    end

    // Read mux: zero unless enabled, strobed and decoded.
    always_comb begin
        rdata = '0;
        if (blk_en && rd_en) begin
            if (hit_ctrl) begin
                rdata[CB_RUN]     = run_q;
                rdata[CB_FIRED]   = fired_q;
                rdata[CB_ACTION]  = act_q;
                rdata[CB_DISABLE] = dis_q;
            end else if (hit_cnt) begin
                rdata[CNT_W-1:0] = cnt_q;
            end
        end
    end

endmodule

// File: rtl/wdog_periph.sv
// Watchdog peripheral top: ties register decode, tick prescaler and countdown.
// Assumes blk_en comes from a power-management enable already synchronised.
module wdog_periph
    import wdog_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd50_000_000,
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 32,
    parameter int              CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_en,
    input  logic [1:0]        res_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              reboot_req,
    output logic              shutdown_req
);
    logic             run_q;
    logic             act_q;
    logic             dis_q;
    logic [CNT_W-1:0] tmo_q;
    logic             reload;
    logic             fired_clr;
    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic             tick;
    logic             active;
    logic             pre_en;

    assign active = blk_en && run_q;
    assign pre_en = active && (cnt_q != '0);

    wdog_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_en   (blk_en),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt_q    (cnt_q),
        .fired_q  (fired_q),
        .run_q    (run_q),
        .act_q    (act_q),
        .dis_q    (dis_q),
        .tmo_q    (tmo_q),
        .reload   (reload),
        .fired_clr(fired_clr),
        .rdata    (rdata)
    );

    wdog_prescale #(
        .CLK_HZ(CLK_HZ)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (pre_en),
        .restart(reload),
        .res_sel(res_sel),
        .tick   (tick)
    );

    wdog_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .tick        (tick),
        .reload      (reload),
        .reload_val  (tmo_q),
        .block_exp   (dis_q),
        .act_sd      (act_q),
        .fired_clr   (fired_clr),
        .cnt_q       (cnt_q),
        .fired_q     (fired_q),
        .reboot_req  (reboot_req),
        .shutdown_req(shutdown_req)
    );

endmodule

// File: rtl/wdog_chk.sv
// Property checker for the watchdog peripheral, attached by bind.
// Assumes it observes the top's internal count, flag and control state.
module wdog_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blk_en,
    input logic             wr_en,
    input logic             run_q,
    input logic             dis_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             fired_q,
    input logic             reboot_req,
    input logic             shutdown_req
);
    p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> $stable(cnt_q));

    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt_q != '0) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_en) |=> $stable(cnt_q));

    p_onehot_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reboot_req && shutdown_req));

    p_reboot_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> !reboot_req);

    p_shutdown_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);

    p_zero_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !wr_en) |=> cnt_q == '0);

    p_fired_on_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reboot_req || shutdown_req) |-> fired_q);

    p_fired_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && !wr_en) |=> fired_q);

    p_block_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reboot_req || shutdown_req) |-> !$past(dis_q));

endmodule

bind wdog_periph wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_en      (blk_en),
    .wr_en       (wr_en),
    .run_q       (run_q),
    .dis_q       (dis_q),
    .cnt_q       (cnt_q),
    .fired_q     (fired_q),
    .reboot_req  (reboot_req),
    .shutdown_req(shutdown_req)
);

// File: tb/tb_wdog_periph.sv
// Self-checking bench for wdog_periph: directed corners plus seeded random
// countdown checks. Runs the block at a scaled reference frequency.
module tb_wdog_periph;
    localparam longint unsigned HZ = 64'd100000;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_CNT  = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_en = 1'b1;
    logic [1:0]  res_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        reboot_req;
    logic        shutdown_req;

    int checks = 0;
    int errors = 0;
    int rb_cnt = 0;
    int sd_cnt = 0;
    bit done = 1'b0;

    wdog_periph #(.CLK_HZ(HZ)) dut (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .res_sel(res_sel),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .reboot_req(reboot_req), .shutdown_req(shutdown_req)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (reboot_req)   rb_cnt++;
            if (shutdown_req) sd_cnt++;
        end
    end

    function automatic int div_for(input int sel);
        longint unsigned us;
        longint unsigned c;
        us = (sel == 0) ? 32 : (sel == 1) ? 10000 : (sel == 2) ? 100000 : 1000000;
        c = HZ * us / 1000000;
        return (c == 0) ? 1 : int'(c);
    endfunction

    function automatic int exp_count(input int t, input int d, input int w);
        return (w >= t * d) ? 0 : t - w / d;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int t;
        int w;
        void'($urandom(32'h1234ABCD));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_CNT, v);  chk("R1 count", v, 32'h0);
        chk("R1 reqs", {30'd0, reboot_req, shutdown_req}, 32'h0);

        // R4 readback, reserved and kick bits read zero
        wr(A_CTRL, 32'hFFFF_FF7C);
        rd(A_CTRL, v); chk("R4 ctrl readback", v, 32'h0C);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R4 ctrl cleared", v, 32'h0);

        // R3 timeout low half, upper read zero
        wr(A_CNT, 32'hABCD_1234);
        wr(A_CTRL, 32'h81);
        rd(A_CNT, v);  chk("R3 count read", v, 32'h0000_1234);
        rd(A_CTRL, v); chk("R4 kick reads 0", v, 32'h01);
        wr(A_CTRL, 32'h0);

        // R3 zero promoted to one
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h81);
        rd(A_CNT, v); chk("R3 zero clamp", v, 32'h1);
        wr(A_CTRL, 32'h0);

        // R5 kick without run ignored
        wr(A_CNT, 32'd50);
        wr(A_CTRL, 32'h80);
        rd(A_CNT, v); chk("R5 kick needs run", v, 32'h1);

        // R6 / R7 countdown, freeze and phase retention at resolution 0
        res_sel = 2'd0;
        wr(A_CNT, 32'd20);
        wr(A_CTRL, 32'h81);
        wait_cyc(10);
        rd(A_CNT, v); chk("R6 res0 count", v, 32'(exp_count(20, div_for(0), 10)));
        wr(A_CTRL, 32'h0);
        wait_cyc(50);
        rd(A_CNT, v); chk("R7 frozen", v, 32'd17);
        wr(A_CTRL, 32'h01);
        rd(A_CNT, v); chk("R7 resume no kick", v, 32'd17);
        wait_cyc(1);
        rd(A_CNT, v); chk("R7 phase kept", v, 32'd16);
        wr(A_CTRL, 32'h0);

        // R8 reboot expiry
        wr(A_CNT, 32'd4);
        wr(A_CTRL, 32'h81);
        wait_cyc(11);
        rd(A_CNT, v); chk("R8 before expiry", v, 32'd1);
        chk("R8 no early req", {31'd0, reboot_req}, 32'd0);
        wait_cyc(1);
        chk("R8 reboot pulse", {30'd0, reboot_req, shutdown_req}, 32'h2);
        rd(A_CNT, v); chk("R8 count zero", v, 32'd0);
        wait_cyc(1);
        chk("R8 pulse one cycle", {31'd0, reboot_req}, 32'd0);
        rd(A_CTRL, v); chk("R9 fired set", v, 32'h03);
        wait_cyc(20);
        rd(A_CNT, v); chk("R8 stays zero", v, 32'd0);
        chk("R8 single reboot", 32'(rb_cnt), 32'd1);

        // R9 sticky and write-one-to-clear
        wr(A_CTRL, 32'h01);
        rd(A_CTRL, v); chk("R9 write 0 keeps", v, 32'h03);
        wr(A_CTRL, 32'h03);
        rd(A_CTRL, v); chk("R9 w1c", v, 32'h01);

        // R8 shutdown expiry
        wr(A_CNT, 32'd2);
        wr(A_CTRL, 32'h85);
        wait_cyc(6);
        chk("R8 shutdown pulse", {30'd0, reboot_req, shutdown_req}, 32'h1);
        wait_cyc(1);
        chk("R8 shutdown count", 32'(sd_cnt), 32'd1);
        rd(A_CTRL, v); chk("R9 fired after shutdown", v, 32'h07);
        wr(A_CTRL, 32'h02);
        rd(A_CTRL, v); chk("R9 cleared", v, 32'h0);

        // R10 expiry blocked
        wr(A_CNT, 32'd2);
        wr(A_CTRL, 32'h89);
        wait_cyc(10);
        rd(A_CNT, v);  chk("R10 count zero", v, 32'd0);
        rd(A_CTRL, v); chk("R10 no fired", v, 32'h09);
        chk("R10 no reqs", 32'(rb_cnt + sd_cnt), 32'd2);
        wr(A_CTRL, 32'h0);

        // R2 block enable gating
        wr(A_CNT, 32'd30);
        wr(A_CTRL, 32'h81);
        wait_cyc(8);
        rd(A_CNT, v); chk("R2 pre-gate count", v, 32'd28);
        blk_en = 1'b0;
        rd(A_CTRL, v); chk("R2 ctrl reads 0", v, 32'h0);
        rd(A_CNT, v);  chk("R2 count reads 0", v, 32'h0);
        wr(A_CNT, 32'd5);
        wr(A_CTRL, 32'h0);
        wait_cyc(30);
        blk_en = 1'b1;
        rd(A_CNT, v);  chk("R2 count held", v, 32'd28);
        rd(A_CTRL, v); chk("R2 ctrl write ignored", v, 32'h01);
        wr(A_CTRL, 32'h81);
        rd(A_CNT, v);  chk("R2 timeout write ignored", v, 32'd30);
        wr(A_CTRL, 32'h0);

        // R11 unmapped offset
        wr(8'h08, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R11 ctrl untouched", v, 32'h0);
        rd(8'h08, v);  chk("R11 read zero", v, 32'h0);
        rd(A_CNT, v);  chk("R11 count untouched", v, 32'd30);

        // R6 resolution 1
        res_sel = 2'd1;
        wr(A_CNT, 32'd2);
        wr(A_CTRL, 32'h81);
        wait_cyc(div_for(1) - 1);
        rd(A_CNT, v); chk("R6 res1 before tick", v, 32'd2);
        wait_cyc(1);
        rd(A_CNT, v); chk("R6 res1 tick", v, 32'd1);
        wr(A_CTRL, 32'h0);

        // R6 resolution 2 with expiry
        res_sel = 2'd2;
        wr(A_CNT, 32'd1);
        wr(A_CTRL, 32'h81);
        wait_cyc(div_for(2) - 1);
        rd(A_CNT, v); chk("R6 res2 before tick", v, 32'd1);
        wait_cyc(1);
        rd(A_CNT, v); chk("R6 res2 expired", v, 32'd0);
        chk("R8 res2 reboot", {31'd0, reboot_req}, 32'd1);
        wr(A_CTRL, 32'h02);

        // R6 resolution 3
        res_sel = 2'd3;
        wr(A_CNT, 32'd5);
        wr(A_CTRL, 32'h81);
        wait_cyc(div_for(3) - 1);
        rd(A_CNT, v); chk("R6 res3 before tick", v, 32'd5);
        wait_cyc(1);
        rd(A_CNT, v); chk("R6 res3 tick", v, 32'd4);
        wr(A_CTRL, 32'h0);

        // R6 random countdowns
        res_sel = 2'd0;
        for (int i = 0; i < 25; i++) begin
            t = 1 + int'($urandom_range(29));
            w = int'($urandom_range(t * div_for(0) - 1));
            wr(A_CNT, 32'(t));
            wr(A_CTRL, 32'h81);
            wait_cyc(w);
            rd(A_CNT, v); chk("R6 random res0", v, 32'(exp_count(t, div_for(0), w)));
            wr(A_CTRL, 32'h0);
        end
        res_sel = 2'd1;
        for (int i = 0; i < 4; i++) begin
            t = 1 + int'($urandom_range(2));
            w = int'($urandom_range(t * div_for(1) - 1));
            wr(A_CNT, 32'(t));
            wr(A_CTRL, 32'h81);
            wait_cyc(w);
            rd(A_CNT, v); chk("R6 random res1", v, 32'(exp_count(t, div_for(1), w)));
            wr(A_CTRL, 32'h0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before the bench completed");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule